// File: doc/BRIEF.md
# Limit-Cycle Period Extractor

This block measures the period of a small self-oscillation in the error sample of a digitally regulated power stage. After a start-identification pulse it watches the sign class of the error, which is sampled once per switching period on a strobe. It counts strobes from the first zero crossing to the third one, so the count spans one full oscillation period. The count is held on the period output, and a done flag is raised.

If no oscillation appears within a fixed number of strobes, the block reports a zero period and raises the no-oscillation flag. It then issues a one-cycle request to shift the voltage reference by one LSB and starts the measurement again. The direction of the shift pushes the error toward the sign boundary. This provokes an oscillation and keeps its positive and negative excursions close to balanced. After a limited number of such attempts the block gives up and raises a failure flag.

Top module: `lco_period_meter`

## Requirements
- R1: After reset, `period_o`, `done_o`, `no_osc_o`, `nudge_o`, `nudge_up_o` and `fail_o` are all 0.
- R2: A `start_i` pulse clears `period_o`, `done_o`, `no_osc_o` and `fail_o` in the next cycle and begins a new measurement. This also applies when a measurement is already running, which is then abandoned.
- R3: A zero crossing is a change of the error's sign class between two successive strobes. Class 1 is error > 0 (two's complement) and class 0 is error <= 0. A change between 0 and a positive value is a crossing; a change between 0 and a negative value is not.
- R4: `period_o` equals the number of strobes from the strobe of the first crossing to the strobe of the third crossing. `done_o` rises in the cycle after that third strobe. Both then hold until the next start, and later strobes are ignored.
- R5: The error input is only sampled in cycles where `strobe_i` is 1. Changes of the error in other cycles have no effect.
- R6: If TIMEOUT strobes (default 255) pass since the measurement (re)started without a third crossing, `period_o` becomes 0 and `no_osc_o` becomes 1.
- R7: On such a timeout with retries left, `nudge_o` is high for exactly one cycle and the measurement restarts. `nudge_up_o` is 1 (+1 LSB) if the error sampled at that strobe is <= 0, and 0 (−1 LSB) if it is > 0.
- R8: A measurement that completes after one or more nudges reports its period and clears `no_osc_o`.
- R9: At most MAX_TRIES (default 3) nudges are made per identification. A further timeout sets `fail_o` and `done_o` with `period_o` = 0, and issues no nudge.
- R10: The period count saturates at 2^CNT_W−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-identification pulse |
| strobe_i | input | 1 | Switching-period sample strobe |
| err_i | input | ERR_W | Signed error sample |
| period_o | output | CNT_W | Measured period in strobes (0 = none) |
| done_o | output | 1 | Measurement finished (success or failure) |
| no_osc_o | output | 1 | Last attempt timed out without oscillation |
| nudge_o | output | 1 | One-cycle reference shift request |
| nudge_up_o | output | 1 | Shift direction: 1 = +1 LSB, 0 = −1 LSB |
| fail_o | output | 1 | Retries exhausted |

## Verification
The assertions check several flag relations on every cycle:
- the nudge pulse lasts one cycle and only follows a strobe;
- a nudge coincides with a zero period and the no-oscillation flag;
- a failure always carries done and a zero period;
- a start clears the results;
- a finished result stays stable until the next start.

Only the bench scenarios can show that the counted period is the right one for a given waveform. The same holds for:
- how a zero-valued error is classified;
- that glitches between strobes are ignored;
- the choice of nudge direction;
- that the retry limit is honoured;
- that the count saturates.

// File: rtl/lco_pkg.sv
package lco_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DONE = 2'd2
    } lco_state_e;
endpackage

// File: rtl/lco_sign_track.sv
// Remembers the sign class of the last strobed error sample and flags a
// class change (zero crossing) on the current strobe.
module lco_sign_track #(
    parameter int ERR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             smp_i,
    input  logic [ERR_W-1:0] err_i,
    output logic             pos_o,
    output logic             xing_o
);
    logic prev_q, valid_q;

    // class 1: strictly positive; class 0: zero or negative
    assign pos_o  = (err_i[ERR_W-1] == 1'b0) && (err_i != '0);
    assign xing_o = smp_i && valid_q && (pos_o != prev_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (clr_i) begin
            valid_q <= 1'b0;
        end else if (smp_i) begin
            prev_q  <= pos_o;
            valid_q <= 1'b1;
        end
    end
endmodule

// File: rtl/lco_sat_count.sv
// Saturating up-counter; clear has priority over increment.
module lco_sat_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] cnt_q;

    assign cnt_o = cnt_q;
    assign nxt_o = (&cnt_q) ? cnt_q : cnt_q + W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= nxt_o;
    end
endmodule

// File: rtl/lco_period_meter.sv
module lco_period_meter
    import lco_pkg::*;
#(
    parameter int ERR_W     = 12,
    parameter int CNT_W     = 8,
    parameter int TIMEOUT   = 255,
    parameter int MAX_TRIES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             strobe_i,
    input  logic [ERR_W-1:0] err_i,
    output logic [CNT_W-1:0] period_o,
    output logic             done_o,
    output logic             no_osc_o,
    output logic             nudge_o,
    output logic             nudge_up_o,
    output logic             fail_o
);
    localparam int TMR_W = $clog2(TIMEOUT + 1);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        lco_state_e       state;
        logic [1:0]       xings;
        logic [TRY_W-1:0] tries;
        logic [CNT_W-1:0] period;
        logic             done;
        logic             no_osc;
        logic             fail;
        logic             nudge;
        logic             nudge_up;
    } regs_t;

    regs_t r_q, r_d;

    logic             trk_clr, pos, xing;
    logic             tmr_clr, tmr_inc, per_clr, per_inc, timeout;
    logic [TMR_W-1:0] tmr_cnt, tmr_nxt;
    logic [CNT_W-1:0] per_cnt, per_nxt;

    lco_sign_track #(.ERR_W(ERR_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .clr_i(trk_clr), .smp_i(strobe_i),
        .err_i(err_i), .pos_o(pos), .xing_o(xing)
    );

    lco_sat_count #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .inc_i(tmr_inc),
        .cnt_o(tmr_cnt), .nxt_o(tmr_nxt)
    );

    lco_sat_count #(.W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .clr_i(per_clr), .inc_i(per_inc),
        .cnt_o(per_cnt), .nxt_o(per_nxt)
    );

    assign timeout = strobe_i && (tmr_cnt == TMR_W'(TIMEOUT - 1));

    always_comb begin
        r_d      = r_q;
        r_d.nudge = 1'b0;
        trk_clr  = 1'b0;
        tmr_clr  = 1'b0;
        tmr_inc  = 1'b0;
        per_clr  = 1'b0;
        per_inc  = 1'b0;

        if (start_i) begin
            r_d.state    = ST_MEAS;
            r_d.xings    = '0;
            r_d.tries    = '0;
            r_d.period   = '0;
            r_d.done     = 1'b0;
            r_d.no_osc   = 1'b0;
            r_d.fail     = 1'b0;
            r_d.nudge_up = 1'b0;
            trk_clr      = 1'b1;
            tmr_clr      = 1'b1;
            per_clr      = 1'b1;
        end else if (r_q.state == ST_MEAS && strobe_i) begin
            tmr_inc = 1'b1;
            if (xing) begin
                case (r_q.xings)
                    2'd0: begin
                        per_clr   = 1'b1;
                        r_d.xings = 2'd1;
                    end
                    2'd1: begin
                        per_inc   = 1'b1;
                        r_d.xings = 2'd2;
                    end
                    default: begin
                        r_d.period = per_nxt;
                        r_d.done   = 1'b1;
                        r_d.no_osc = 1'b0;
                        r_d.state  = ST_DONE;
                    end
                endcase
            end else if (r_q.xings != 2'd0) begin
                per_inc = 1'b1;
            end

            // a third crossing on the timeout strobe wins over the timeout
            if (timeout && !(xing && r_q.xings == 2'd2)) begin
                r_d.period = '0;
                r_d.no_osc = 1'b1;
                if (r_q.tries == TRY_W'(MAX_TRIES)) begin
                    r_d.fail  = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.state = ST_DONE;
                end else begin
                    r_d.nudge    = 1'b1;
                    r_d.nudge_up = !pos;
                    r_d.tries    = r_q.tries + TRY_W'(1);
                    r_d.xings    = '0;
                    trk_clr      = 1'b1;
                    tmr_clr      = 1'b1;
                    per_clr      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.xings    <= '0;
            r_q.tries    <= '0;
            r_q.period   <= '0;
            r_q.done     <= 1'b0;
            r_q.no_osc   <= 1'b0;
            r_q.fail     <= 1'b0;
            r_q.nudge    <= 1'b0;
            r_q.nudge_up <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign period_o   = r_q.period;
    assign done_o     = r_q.done;
    assign no_osc_o   = r_q.no_osc;
    assign nudge_o    = r_q.nudge;
    assign nudge_up_o = r_q.nudge_up;
    assign fail_o     = r_q.fail;
endmodule

// File: rtl/lco_period_meter_chk.sv
module lco_period_meter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             strobe_i,
    input logic [CNT_W-1:0] period_o,
    input logic             done_o,
    input logic             no_osc_o,
    input logic             nudge_o,
    input logic             fail_o
);
    // R7: the reference request is a single-cycle pulse
    a_r7_nudge_single: assert property (@(posedge clk) disable iff (!rst_n)
        nudge_o |=> !nudge_o);

    // R5: a nudge can only follow a strobed sample
    a_r5_nudge_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        nudge_o |-> $past(strobe_i));

    // R6: a nudge comes with a zero period and the no-oscillation flag
    a_r6_nudge_flags: assert property (@(posedge clk) disable iff (!rst_n)
        nudge_o |-> (no_osc_o && period_o == '0 && !done_o));

    // R9: failure is final and carries a zero period
    a_r9_fail_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (done_o && period_o == '0));

    // R2: start clears the results
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !fail_o && !no_osc_o && period_o == '0));

    // R4: a finished result holds until the next start
    a_r4_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(period_o) && $stable(fail_o)));

    // R8: a successful result never shows the no-oscillation flag
    a_r8_success_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fail_o) |-> !no_osc_o);
endmodule

bind lco_period_meter lco_period_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .strobe_i(strobe_i),
    .period_o(period_o), .done_o(done_o), .no_osc_o(no_osc_o),
    .nudge_o(nudge_o), .fail_o(fail_o)
);

// File: tb/sim_lco_period_meter.sv
module sim_lco_period_meter;
    localparam int ERR_W = 12;
    localparam int CNT_W = 6;   // small width so saturation is reachable

    logic             clk = 1'b0;
    logic             rst_n, start, strobe;
    logic [ERR_W-1:0] err;
    logic [CNT_W-1:0] period;
    logic             done, no_osc, nudge, nudge_up, fail;

    always #4 clk = ~clk;   // 125 MHz

    lco_period_meter #(.ERR_W(ERR_W), .CNT_W(CNT_W), .TIMEOUT(255), .MAX_TRIES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .strobe_i(strobe), .err_i(err),
        .period_o(period), .done_o(done), .no_osc_o(no_osc), .nudge_o(nudge),
        .nudge_up_o(nudge_up), .fail_o(fail)
    );

    typedef struct {
        int    per;
        bit    nosc;
        bit    fl;
        int    nudges;
        bit    up;
        string req;
    } exp_t;

    exp_t sb[$];
    exp_t e;
    int   checks = 0, errors = 0;
    int   nudge_cnt = 0;
    bit   nudge_last = 1'b0;
    bit   done_prev = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_item(input int p, input bit n, input bit f,
                               input int nd, input bit up, input string req);
        exp_t x;
        x.per = p; x.nosc = n; x.fl = f; x.nudges = nd; x.up = up; x.req = req;
        sb.push_back(x);
    endtask

    // monitor: counts nudges, compares each finished result with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (nudge) begin
                nudge_cnt++;
                nudge_last = nudge_up;
            end
            if (done && !done_prev) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected result: actual period %0d expected none", period);
                end else begin
                    e = sb.pop_front();
                    if (int'(period) != e.per || no_osc != e.nosc || fail != e.fl ||
                        nudge_cnt != e.nudges || (e.nudges > 0 && nudge_last != e.up)) begin
                        errors++;
                        $display("FAIL %s result: actual p=%0d nosc=%0d fail=%0d nudges=%0d up=%0d expected p=%0d nosc=%0d fail=%0d nudges=%0d up=%0d",
                                 e.req, period, no_osc, fail, nudge_cnt, nudge_last,
                                 e.per, e.nosc, e.fl, e.nudges, e.up);
                    end
                end
            end
            done_prev = done;
        end
    end

    // driver tasks: each starts and ends just after a falling edge
    task automatic do_start();
        nudge_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // one strobed sample, then a non-strobe cycle with the opposite error (R5 glitch)
    task automatic strobe_one(input int v);
        err    = ERR_W'(v);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        err    = ERR_W'(-v);
        @(negedge clk);
    endtask

    task automatic square(input int a, input int b, input int h, input int n);
        for (int i = 0; i < n; i++) strobe_one(((i / h) % 2 == 0) ? a : b);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; strobe = 1'b0; err = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(period == '0 && !done && !no_osc && !nudge && !nudge_up && !fail,
              "R1", "reset outputs", int'({period, done, no_osc, nudge, nudge_up, fail}), 0);

        // R4, R5: square wave, half period 5 strobes -> period 10
        expect_item(10, 0, 0, 0, 0, "R4");
        do_start();
        square(5, -5, 5, 20);
        check(done && period == 6'd10, "R4", "held period", int'(period), 10);

        // R2: start after a result clears it; R3: zero counts as non-positive
        do_start();
        check(!done && period == '0, "R2", "cleared by start", int'({done, period}), 0);
        expect_item(6, 0, 0, 0, 0, "R3");
        square(4, 0, 3, 12);

        // R2: restart during a measurement
        expect_item(12, 0, 0, 0, 0, "R2");
        do_start();
        square(5, -5, 5, 7);
        check(!done, "R2", "no result mid-run", int'(done), 0);
        do_start();
        square(5, -5, 6, 24);

        // R6, R7, R8: 0/-3 has no crossing -> timeout, nudge up, then success
        expect_item(8, 0, 0, 1, 1, "R8");
        do_start();
        square(0, -3, 1, 255);
        check(no_osc && period == '0 && !done, "R6", "timeout flags",
              int'({no_osc, done}), 2);
        check(nudge_cnt == 1, "R7", "one nudge", nudge_cnt, 1);
        check(nudge_last == 1'b1, "R7", "nudge up for non-positive error", int'(nudge_last), 1);
        square(6, -6, 4, 16);

        // R9, R7: constant positive error -> three nudges down, then failure
        expect_item(0, 1, 1, 3, 0, "R9");
        do_start();
        square(7, 7, 1, 255);
        check(nudge_last == 1'b0, "R7", "nudge down for positive error", int'(nudge_last), 0);
        square(7, 7, 1, 765);
        check(fail && done && nudge_cnt == 3, "R9", "retry limit",
              nudge_cnt, 3);

        // R10: period 80 saturates at 63
        expect_item(63, 0, 0, 0, 0, "R10");
        do_start();
        square(9, -9, 40, 125);
        check(period == 6'd63, "R10", "saturated period", int'(period), 63);

        check(sb.size() == 0, "R4", "pending results", sb.size(), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule